// File: doc/BRIEF.md
# DMA Request Arbiter with Inter-Channel Cascading

This block decides which of ten DMA channels may perform the next single transfer. Each channel picks one request source through a small select field: a software trigger bit, one of four peripheral request lines (converter conversion complete, timer event, serial receive complete, serial transmit buffer empty), or a cascade event. A cascade event is raised for a channel when a linked channel reports completion. The links form a fixed, irregular table, and one link fires only when a channel's transfer count underflows.

Each accepted request sets a pending flag for its channel. The flag holds until the channel is granted. On each cycle in which the transfer engine is idle, the block picks the lowest-numbered enabled channel that has a pending flag. It then presents a registered one-hot grant with a valid strobe. Service is one transfer per grant, so a channel that needs several transfers must request again, or be re-triggered by a cascade, before each one. The arbitration repeats before every transfer.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `grant` is all zeros and `grant_vld` is low. No channel is pending after reset.
- R2: A channel's 3-bit field in `ch_src` (bits `3*c+2 : 3*c` for channel c) selects its only request source. Code 0 is `sw_trig[c]`. Code 1 is `periph_req[0]` (converter), code 2 is `periph_req[1]` (timer), code 3 is `periph_req[2]` (serial receive), code 4 is `periph_req[3]` (serial transmit). Code 5 is the cascade event. Codes 6 and 7 accept nothing. A pulse on any source that is not selected leaves the channel unrequested.
- R3: A `xfer_done` pulse raises a cascade event on exactly one other channel, following these links (finishing channel to started channel): 2 to 0, 0 to 1, 1 to 2, 3 to 4, 7 to 5, 5 to 6, 6 to 7, 8 to 9. A `xfer_done` pulse on channels 4 and 9 raises none.
- R4: A `cnt_uflow[0]` pulse raises a cascade event on channel 5. An underflow pulse on any other channel raises none.
- R5: When several enabled channels are pending, the lowest-numbered one is granted first. The others follow in ascending order on later idle cycles.
- R6: `grant` has at most one bit set. `grant_vld` is high exactly when a bit is set.
- R7: A pending flag stays set until its channel is granted and is cleared by that grant. A second request for a channel that is already pending merges with the first and yields a single grant. An enabled pending channel is granted on the next cycle whenever the engine is idle.
- R8: A channel whose `ch_en` bit is low is never granted. Requests arriving for it are discarded, and a pending flag is dropped when the channel is disabled. Re-enabling the channel does not bring back a discarded request.
- R9: While `eng_busy` is high no grant is issued on the following cycle. Pending flags are kept and are served once it falls.
- R10: A request pulse sampled at clock edge k is first visible as a grant after clock edge k+1, when the engine is idle and no higher-priority channel is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 10 | Per-channel enable |
| ch_src | input | 30 | Per-channel 3-bit request source select |
| sw_trig | input | 10 | Per-channel software trigger pulses |
| periph_req | input | 4 | Peripheral request pulses: converter, timer, serial receive, serial transmit |
| xfer_done | input | 10 | Per-channel single-transfer completion pulses |
| cnt_uflow | input | 10 | Per-channel transfer count underflow pulses |
| eng_busy | input | 1 | Transfer engine busy; blocks new grants |
| grant | output | 10 | One-hot grant, registered |
| grant_vld | output | 1 | Grant valid strobe, registered |

## Verification
The bound checker tests several properties on every cycle. It checks that the grant is one-hot with a matching valid bit, and that no grant follows a busy cycle. It checks that no granted channel was disabled, and that no lower-numbered enabled pending channel was passed over. It also checks that an idle engine with an eligible pending channel always receives a grant. Some behaviour can only be shown by the directed scenarios: the exact cascade link table, the underflow-only link, and the source-select decoding. The same holds for request merging, the discarding of requests to disabled channels, and the two-edge request-to-grant latency. These scenarios drive known pulses and compare the grant sequence against expected values.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Source-select codes; peripheral lines occupy codes 1 .. 4
  localparam int SRC_SW   = 0;
  localparam int SRC_PER0 = 1;
  localparam int SRC_CASC = 5;

  // Channel whose single-transfer completion starts channel dst (-1: none)
  function automatic int single_link_src(input int dst);
    case (dst)
      0:       return 2;
      1:       return 0;
      2:       return 1;
      4:       return 3;
      5:       return 7;
      6:       return 5;
      7:       return 6;
      9:       return 8;
      default: return -1;
    endcase
  endfunction

  // Channel whose count underflow starts channel dst (-1: none)
  function automatic int uflow_link_src(input int dst);
    return (dst == 5) ? 0 : -1;
  endfunction
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel
  import dma_arb_pkg::*;
#(
  parameter int SRC_W = 3,
  parameter int NPER  = 4
) (
  input  logic [SRC_W-1:0] sel,
  input  logic             sw,
  input  logic [NPER-1:0]  periph,
  input  logic             casc,
  output logic             req
);
  always_comb begin
    req = 1'b0;
    if (sel == SRC_W'(SRC_SW)) req = sw;
    if (sel == SRC_W'(SRC_CASC)) req = casc;
    for (int p = 0; p < NPER; p++) begin
      if (sel == SRC_W'(SRC_PER0 + p)) req = periph[p];
    end
  end
endmodule

// File: rtl/dma_pend_bank.sv
module dma_pend_bank #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] en,
  input  logic [NUM_CH-1:0] set,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] pend
);
  // A new request wins over a same-cycle grant; disabled channels drop all
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= ((pend & ~clr) | set) & en;
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 10
) (
  input  logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] win
);
  // Scan from the lowest priority up so the lowest index is written last
  always_comb begin
    win = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win    = '0;
        win[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int SRC_W  = 3,
  parameter int NPER   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*SRC_W-1:0] ch_src,
  input  logic [NUM_CH-1:0]       sw_trig,
  input  logic [NPER-1:0]         periph_req,
  input  logic [NUM_CH-1:0]       xfer_done,
  input  logic [NUM_CH-1:0]       cnt_uflow,
  input  logic                    eng_busy,
  output logic [NUM_CH-1:0]       grant,
  output logic                    grant_vld
);
  logic [NUM_CH-1:0] casc_evt;
  logic [NUM_CH-1:0] casc_single;
  logic [NUM_CH-1:0] casc_uflow;
  logic [NUM_CH-1:0] req_in;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] win;
  logic              casc_unused;

  assign casc_unused = ^{xfer_done, cnt_uflow};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LS = single_link_src(c);
    localparam int LU = uflow_link_src(c);

    if (LS >= 0 && LS < NUM_CH) begin : g_single
      assign casc_single[c] = xfer_done[LS];
    end else begin : g_no_single
      assign casc_single[c] = 1'b0;
    end

    if (LU >= 0 && LU < NUM_CH) begin : g_uflow
      assign casc_uflow[c] = cnt_uflow[LU];
    end else begin : g_no_uflow
      assign casc_uflow[c] = 1'b0;
    end

    assign casc_evt[c] = casc_single[c] | casc_uflow[c];

    dma_req_sel #(.SRC_W(SRC_W), .NPER(NPER)) sel_i (
      .sel    (ch_src[c*SRC_W +: SRC_W]),
      .sw     (sw_trig[c]),
      .periph (periph_req),
      .casc   (casc_evt[c]),
      .req    (req_in[c])
    );
  end

  assign elig = pend_q & ch_en & {NUM_CH{~eng_busy}};

  dma_prio_pick #(.NUM_CH(NUM_CH)) pick_i (
    .elig (elig),
    .win  (win)
  );

  dma_pend_bank #(.NUM_CH(NUM_CH)) pend_i (
    .clk  (clk),
    .rst  (rst),
    .en   (ch_en),
    .set  (req_in),
    .clr  (win),
    .pend (pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= '0;
      grant_vld <= 1'b0;
    end else begin
      grant     <= win;
      grant_vld <= |win;
    end
  end
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NUM_CH = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_en,
  input logic              eng_busy,
  input logic [NUM_CH-1:0] grant,
  input logic              grant_vld,
  input logic [NUM_CH-1:0] pend
);
  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6
  vld_match_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld == (grant != '0));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> !grant_vld);

  // R8
  disabled_grant_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> ((grant & $past(ch_en)) == grant));

  // R5
  priority_order_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> ((($past(pend) & $past(ch_en)) & (grant - NUM_CH'(1))) == '0));

  // R7
  idle_serve_chk: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && ((pend & ch_en) != '0)) |=> grant_vld);
endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ch_en     (ch_en),
  .eng_busy  (eng_busy),
  .grant     (grant),
  .grant_vld (grant_vld),
  .pend      (pend_q)
);

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 10;
  localparam int SRC_W  = 3;
  localparam int NPER   = 4;

  logic                    clk = 1'b0;
  logic                    rst;
  logic [NUM_CH-1:0]       ch_en;
  logic [NUM_CH*SRC_W-1:0] ch_src;
  logic [NUM_CH-1:0]       sw_trig;
  logic [NPER-1:0]         periph_req;
  logic [NUM_CH-1:0]       xfer_done;
  logic [NUM_CH-1:0]       cnt_uflow;
  logic                    eng_busy;
  logic [NUM_CH-1:0]       grant;
  logic                    grant_vld;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_req_arbiter #(.NUM_CH(NUM_CH), .SRC_W(SRC_W), .NPER(NPER)) dut_i (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_src(ch_src), .sw_trig(sw_trig),
    .periph_req(periph_req), .xfer_done(xfer_done), .cnt_uflow(cnt_uflow),
    .eng_busy(eng_busy), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_grant(input logic [NUM_CH-1:0] exp, input string tag);
    n_chk++;
    if (grant !== exp || grant_vld !== (exp != '0)) begin
      n_err++;
      $display("FAIL %s: grant=%b vld=%b, expected grant=%b vld=%b",
               tag, grant, grant_vld, exp, (exp != '0));
    end
  endtask

  task automatic all_src(input int code);
    for (int c = 0; c < NUM_CH; c++) ch_src[c*SRC_W +: SRC_W] = SRC_W'(code);
  endtask

  task automatic set_src(input int c, input int code);
    ch_src[c*SRC_W +: SRC_W] = SRC_W'(code);
  endtask

  // Drive the given pulses for one cycle, release them, wait one more edge
  task automatic pulse(input logic [NUM_CH-1:0] sw, input logic [NPER-1:0] per,
                       input logic [NUM_CH-1:0] dn, input logic [NUM_CH-1:0] uf);
    sw_trig = sw; periph_req = per; xfer_done = dn; cnt_uflow = uf;
    step();
    sw_trig = '0; periph_req = '0; xfer_done = '0; cnt_uflow = '0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; ch_en = '1; all_src(0); sw_trig = '0; periph_req = '0;
    xfer_done = '0; cnt_uflow = '0; eng_busy = 1'b0;
    repeat (3) step();
    check_grant('0, "R1 during reset");
    sw_trig = 10'b0000010000;
    step();
    check_grant('0, "R1 request during reset");
    sw_trig = '0;
    rst = 1'b0;
    step();
    check_grant('0, "R1 first cycle after reset");
    step();
    check_grant('0, "R1 nothing pending after reset");
  endtask

  task automatic t_sw_latency();
    all_src(0);
    sw_trig = 10'b0000001000;
    step();
    sw_trig = '0;
    check_grant('0, "R10 no grant one edge after request");
    step();
    check_grant(10'b0000001000, "R10 grant two edges after request");
    step();
    check_grant('0, "R10 single grant per request");
  endtask

  task automatic t_src_select();
    all_src(0);
    set_src(4, 1);
    pulse(10'b0000010000, '0, '0, '0);
    check_grant('0, "R2 sw ignored when converter selected");
    pulse('0, 4'b0010, '0, '0);
    check_grant('0, "R2 timer ignored when converter selected");
    pulse('0, 4'b0001, '0, '0);
    check_grant(10'b0000010000, "R2 converter selected");
    step();
    set_src(4, 4);
    pulse('0, 4'b1000, '0, '0);
    check_grant(10'b0000010000, "R2 serial transmit selected");
    step();
    set_src(4, 7);
    pulse(10'b0000010000, 4'b1111, 10'b0000001000, '0);
    check_grant('0, "R2 code 7 accepts nothing");
    all_src(0);
    step();
  endtask

  task automatic t_priority();
    all_src(0);
    pulse(10'b1010000100, '0, '0, '0);
    check_grant(10'b0000000100, "R5 channel 2 first");
    step();
    check_grant(10'b0010000000, "R5 channel 7 second");
    step();
    check_grant(10'b1000000000, "R5 channel 9 third");
    step();
    check_grant('0, "R5 queue empty");
  endtask

  task automatic t_cascade();
    all_src(5);
    pulse('0, '0, 10'b0000000001, '0);
    check_grant(10'b0000000010, "R3 done 0 starts 1");
    step(); check_grant('0, "R3 done 0 starts nothing else");
    pulse('0, '0, 10'b0000000100, '0);
    check_grant(10'b0000000001, "R3 done 2 starts 0");
    step();
    pulse('0, '0, 10'b0010000000, '0);
    check_grant(10'b0000100000, "R3 done 7 starts 5");
    step();
    pulse('0, '0, 10'b0000001000, '0);
    check_grant(10'b0000010000, "R3 done 3 starts 4");
    step();
    pulse('0, '0, 10'b0100000000, '0);
    check_grant(10'b1000000000, "R3 done 8 starts 9");
    step();
    pulse('0, '0, 10'b1000010000, '0);
    check_grant('0, "R3 done 4 and 9 start nothing");
    step(); check_grant('0, "R3 done 4 and 9 start nothing later");
    all_src(0);
  endtask

  task automatic t_uflow();
    all_src(5);
    pulse('0, '0, '0, 10'b0000000001);
    check_grant(10'b0000100000, "R4 underflow 0 starts 5");
    step();
    pulse('0, '0, '0, 10'b1111111110);
    check_grant('0, "R4 other underflows start nothing");
    step(); check_grant('0, "R4 other underflows start nothing later");
    all_src(0);
  endtask

  task automatic t_busy_merge();
    all_src(0);
    eng_busy = 1'b1;
    pulse(10'b0001000000, '0, '0, '0);
    check_grant('0, "R9 no grant while busy");
    pulse(10'b0001000000, '0, '0, '0);
    check_grant('0, "R9 still no grant while busy");
    eng_busy = 1'b0;
    step();
    check_grant(10'b0001000000, "R7 pending served after busy");
    step();
    check_grant('0, "R7 merged request granted once");
  endtask

  task automatic t_disable();
    all_src(0);
    ch_en[2] = 1'b0;
    pulse(10'b0000000100, '0, '0, '0);
    check_grant('0, "R8 disabled channel not granted");
    ch_en[2] = 1'b1;
    step(); step();
    check_grant('0, "R8 request to disabled channel discarded");
    eng_busy = 1'b1;
    pulse(10'b0000000010, '0, '0, '0);
    ch_en[1] = 1'b0;
    step();
    ch_en[1] = 1'b1;
    eng_busy = 1'b0;
    step();
    check_grant('0, "R8 pending dropped on disable");
    step();
    check_grant('0, "R8 pending stays dropped");
  endtask

  initial begin
    t_reset();
    t_sw_latency();
    t_src_select();
    t_priority();
    t_cascade();
    t_uflow();
    t_busy_merge();
    t_disable();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule